// File: doc/BRIEF.md
# SMBus target register responder

This block sits between a bit-level I2C target engine and a small register file. The engine reports bus activity to it as one-cycle event pulses: a START or repeated START, a STOP, a match of the block's own address together with the transfer direction, a byte received from the host, and a byte that the host has just clocked in together with the host's ACK or NACK. In return the block decides whether to acknowledge each received byte, and it presents the next byte to shift out while it holds the right to drive data.

The first byte that the host writes after the block's address is a command. The command selects a register index and an access kind: a single byte, a 16-bit word sent low byte first, or a count-prefixed block of up to NREG bytes. The command is kept as a persistent pointer. A bare read that has no command in front of it therefore returns data from the register chosen by the last command. Write data is collected in a staging buffer and copied into the registers only when the STOP arrives. When packet error checking is enabled, a trailing CRC-8 byte must match. If it does not match, the staged data is dropped.

Top module: `smbus_reg_responder`

## Requirements
- R1: After reset `ack_o` is 0, `tx_drive` is 0, `tx_byte` is 0xFF, every register reads 0, the pointer is 0 (byte access, index 0) and the stored block length is 0.
- R2: In a write transfer, the first received byte is ACKed and becomes the pointer. Bits [4:0] give the register index. Bits [6:5] give the access kind: 00 byte, 01 word, 10 or 11 block. Bit 7 is ignored.
- R3: A read transfer that has no command in front of it serves data from the pointer that the most recent command left, across any number of transfers.
- R4: With byte access, the one data byte after the command goes to the indexed register. With checking off, any further data byte is NACKed. A byte read returns the indexed register, and each further byte the host ACKs comes from the next index, modulo 32.
- R5: With word access, the first data byte is written to the index and the second to index+1, modulo 32. A read sends the byte at the index first and the byte at index+1 after it.
- R6: With block access, the byte after the command is a count C. Data byte k (counting from 0) goes to index+k, modulo 32, and is ACKed while k < min(C,32). With checking off, every byte after that is NACKed.
- R7: A block read first sends the number of bytes committed by the last block write that committed (0 after reset). It then sends the registers from the index upward. `tx_byte` does not change while no event other than a byte reception occurs.
- R8: An address match with read direction sets `tx_drive`. A host NACK on a transmitted byte clears `tx_drive` on the next cycle and returns `tx_byte` to 0xFF. A host ACK advances to the next byte.
- R9: A write transfer that ends with a STOP right after the command changes only the pointer, and no register changes.
- R10: When `pec_en` is 1, the first byte after the expected data is taken as a CRC-8 and ACKed. The CRC uses polynomial 0x07, initial value 0, MSB first, and covers the address byte ({OWN_ADDR,0}), the command, the count and the data. Data is committed only if this byte matches. A mismatch or a missing check byte discards the data, and the pointer is still updated. A block count above 32 disables the check byte slot.
- R11: Write data reaches the registers only at a STOP. A START or repeated START before the STOP discards the staged bytes, and a START or STOP clears `tx_drive` on the next cycle.
- R12: `ack_o` shows the decision for a received byte in the cycle after `ev_rx` and holds it until the next byte. A byte received outside an addressed write transfer is NACKed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pec_en | input | 1 | Enables the CRC-8 check byte on writes |
| ev_start | input | 1 | START or repeated START seen (pulse) |
| ev_stop | input | 1 | STOP seen (pulse) |
| ev_addr | input | 1 | Own address matched (pulse) |
| addr_rd | input | 1 | Direction bit of the matched address, 1 = read |
| ev_rx | input | 1 | A byte was received from the host (pulse) |
| rx_byte | input | 8 | The received byte, valid with `ev_rx` |
| ack_o | output | 1 | ACK (1) or NACK (0) for the last received byte |
| ev_tx | input | 1 | The host finished reading a byte (pulse) |
| tx_nack | input | 1 | Host NACKed that byte, valid with `ev_tx` |
| tx_byte | output | 8 | Byte to shift out next, 0xFF when not driving |
| tx_drive | output | 1 | The block owns the data line for reading |

## Verification
The checker watches the event-level rules on every cycle. These are: one event per cycle; NACK of bytes that arrive outside a write transfer; a bound on the number of ACKs in one write transfer; the rise of `tx_drive` on a read address and its fall after a host NACK, START or STOP; and the stability of `tx_byte` between events. Only the bench scenarios can show what ends up in the registers. That covers wrap-around at index 31, clamping of block counts, the persistent pointer, CRC pass and fail, and the dropping of staged data on a repeated START. The bench shows these by reading the data back and comparing it with a model of the register file.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

  typedef enum logic [1:0] {
    TXN_IDLE,
    TXN_WRITE,
    TXN_READ
  } txn_e;

  typedef enum logic [1:0] {
    ACC_BYTE,
    ACC_WORD,
    ACC_BLOCK
  } acc_e;

  function automatic acc_e acc_of(input logic [1:0] kind);
    case (kind)
      2'b00:   return ACC_BYTE;
      2'b01:   return ACC_WORD;
      default: return ACC_BLOCK;
    endcase
  endfunction

endpackage

// File: rtl/smbr_crc8.sv
module smbr_crc8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       upd_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);

  logic [7:0] crc_q, crc_d;

  function automatic logic [7:0] fold(input logic [7:0] acc, input logic [7:0] din);
    logic [7:0] x;
    x = acc ^ din;
    for (int i = 0; i < 8; i++) begin
      x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    end
    return x;
  endfunction

  always_comb begin
    crc_d = crc_q;
    if (clr_i)      crc_d = fold(8'h00, data_i);
    else if (upd_i) crc_d = fold(crc_q, data_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              crc_q <= 8'h00;
    else if (clr_i || upd_i) crc_q <= crc_d;
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/smbr_regfile.sv
module smbr_regfile #(
  parameter  int NREG  = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stg_we,
  input  logic [IDX_W-1:0] stg_idx,
  input  logic [7:0]       stg_byte,
  input  logic             commit,
  input  logic [IDX_W-1:0] base,
  input  logic [IDX_W:0]   ncommit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte
);

  logic [7:0]            stage [NREG];
  logic [NREG-1:0][7:0]  cells;

  always_ff @(posedge clk) begin
    if (stg_we) stage[stg_idx] <= stg_byte;
  end

  for (genvar j = 0; j < NREG; j++) begin : g_cell
    logic [IDX_W-1:0] off;
    logic             hit;
    logic [7:0]       cell_q;

    assign off = IDX_W'(j) - base;
    assign hit = commit && ({1'b0, off} < ncommit);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cell_q <= 8'h00;
      else if (hit) cell_q <= stage[off];
    end

    assign cells[j] = cell_q;
  end

  assign rd_byte = cells[rd_idx];

endmodule

// File: rtl/smbus_reg_responder.sv
module smbus_reg_responder
  import smbr_pkg::*;
#(
  parameter int          NREG     = 32,
  parameter logic [6:0]  OWN_ADDR = 7'h3A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pec_en,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_addr,
  input  logic       addr_rd,
  input  logic       ev_rx,
  input  logic [7:0] rx_byte,
  output logic       ack_o,
  input  logic       ev_tx,
  input  logic       tx_nack,
  output logic [7:0] tx_byte,
  output logic       tx_drive
);

  localparam int IDX_W = $clog2(NREG);
  localparam int CNT_W = IDX_W + 1;
  localparam int PTR_W = IDX_W + 2;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NREG);

  // reset synchronizer: assert asynchronously, release on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  txn_e             txn_q, txn_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             cmd_seen_q, cmd_seen_d, cnt_seen_q, cnt_seen_d;
  logic             over_q, over_d, pec_seen_q, pec_seen_d, pec_ok_q, pec_ok_d;
  logic             ack_q, ack_d, drive_q, drive_d;
  logic [CNT_W-1:0] blk_cnt_q, blk_cnt_d, nacc_q, nacc_d;
  logic [CNT_W-1:0] rd_cnt_q, rd_cnt_d, blk_len_q, blk_len_d;

  acc_e             acc;
  logic [IDX_W-1:0] base, rd_idx;
  logic [CNT_W-1:0] exp_n, rd_off;
  logic             in_wr, stg_we, commit, crc_clr, crc_upd;
  logic [7:0]       crc, rd_byte, crc_in;

  assign acc   = acc_of(ptr_q[PTR_W-1:IDX_W]);
  assign base  = ptr_q[IDX_W-1:0];
  assign in_wr = (txn_q == TXN_WRITE);

  always_comb begin
    case (acc)
      ACC_BYTE: exp_n = ONE;
      ACC_WORD: exp_n = CNT_W'(2);
      default:  exp_n = blk_cnt_q;
    endcase
  end

  assign commit = ev_stop && in_wr && cmd_seen_q && (nacc_q != '0) &&
                  (!pec_en || (pec_seen_q && pec_ok_q));

  always_comb begin
    txn_d      = txn_q;
    ptr_d      = ptr_q;
    cmd_seen_d = cmd_seen_q;
    cnt_seen_d = cnt_seen_q;
    over_d     = over_q;
    pec_seen_d = pec_seen_q;
    pec_ok_d   = pec_ok_q;
    ack_d      = ack_q;
    drive_d    = drive_q;
    blk_cnt_d  = blk_cnt_q;
    nacc_d     = nacc_q;
    rd_cnt_d   = rd_cnt_q;
    blk_len_d  = blk_len_q;
    stg_we     = 1'b0;
    if (ev_start) begin
      txn_d   = TXN_IDLE;
      drive_d = 1'b0;
    end else if (ev_stop) begin
      txn_d   = TXN_IDLE;
      drive_d = 1'b0;
      if (commit && acc == ACC_BLOCK) blk_len_d = nacc_q;
    end else if (ev_addr) begin
      if (addr_rd) begin
        txn_d    = TXN_READ;
        drive_d  = 1'b1;
        rd_cnt_d = '0;
      end else begin
        txn_d      = TXN_WRITE;
        drive_d    = 1'b0;
        cmd_seen_d = 1'b0;
        cnt_seen_d = 1'b0;
        over_d     = 1'b0;
        nacc_d     = '0;
        pec_seen_d = 1'b0;
        pec_ok_d   = 1'b0;
      end
    end else if (ev_rx) begin
      ack_d = 1'b0;
      if (in_wr) begin
        if (!cmd_seen_q) begin
          ptr_d      = rx_byte[PTR_W-1:0];
          cmd_seen_d = 1'b1;
          ack_d      = 1'b1;
        end else if (acc == ACC_BLOCK && !cnt_seen_q) begin
          cnt_seen_d = 1'b1;
          over_d     = rx_byte > 8'(NREG);
          blk_cnt_d  = (rx_byte > 8'(NREG)) ? FULL : rx_byte[CNT_W-1:0];
          ack_d      = 1'b1;
        end else if (nacc_q < exp_n) begin
          stg_we = 1'b1;
          nacc_d = nacc_q + ONE;
          ack_d  = 1'b1;
        end else if (pec_en && !pec_seen_q && !over_q) begin
          pec_seen_d = 1'b1;
          pec_ok_d   = (rx_byte == crc);
          ack_d      = 1'b1;
        end
      end
    end else if (ev_tx && txn_q == TXN_READ && drive_q) begin
      if (tx_nack) drive_d  = 1'b0;
      else         rd_cnt_d = rd_cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      txn_q      <= TXN_IDLE;
      ptr_q      <= '0;
      cmd_seen_q <= 1'b0;
      cnt_seen_q <= 1'b0;
      over_q     <= 1'b0;
      pec_seen_q <= 1'b0;
      pec_ok_q   <= 1'b0;
      ack_q      <= 1'b0;
      drive_q    <= 1'b0;
      blk_cnt_q  <= '0;
      nacc_q     <= '0;
      rd_cnt_q   <= '0;
      blk_len_q  <= '0;
    end else begin
      txn_q      <= txn_d;
      ptr_q      <= ptr_d;
      cmd_seen_q <= cmd_seen_d;
      cnt_seen_q <= cnt_seen_d;
      over_q     <= over_d;
      pec_seen_q <= pec_seen_d;
      pec_ok_q   <= pec_ok_d;
      ack_q      <= ack_d;
      drive_q    <= drive_d;
      blk_cnt_q  <= blk_cnt_d;
      nacc_q     <= nacc_d;
      rd_cnt_q   <= rd_cnt_d;
      blk_len_q  <= blk_len_d;
    end
  end

  assign crc_clr = ev_addr && !addr_rd;
  assign crc_upd = ev_rx && in_wr;
  assign crc_in  = crc_clr ? {OWN_ADDR, 1'b0} : rx_byte;

  smbr_crc8 u_crc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (crc_clr),
    .upd_i  (crc_upd),
    .data_i (crc_in),
    .crc_o  (crc)
  );

  assign rd_off = (acc == ACC_BLOCK) ? (rd_cnt_q - ONE) : rd_cnt_q;
  assign rd_idx = base + rd_off[IDX_W-1:0];

  smbr_regfile #(.NREG(NREG)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .stg_we   (stg_we),
    .stg_idx  (nacc_q[IDX_W-1:0]),
    .stg_byte (rx_byte),
    .commit   (commit),
    .base     (base),
    .ncommit  (nacc_q),
    .rd_idx   (rd_idx),
    .rd_byte  (rd_byte)
  );

  always_comb begin
    if (!drive_q)                               tx_byte = 8'hFF;
    else if (acc == ACC_BLOCK && rd_cnt_q == '0) tx_byte = 8'(blk_len_q);
    else                                        tx_byte = rd_byte;
  end

  assign ack_o    = ack_q;
  assign tx_drive = drive_q;

endmodule

// File: rtl/smbr_checker.sv
module smbr_checker #(
  parameter int NREG = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_addr,
  input logic       addr_rd,
  input logic       ev_rx,
  input logic       ack_o,
  input logic       ev_tx,
  input logic       tx_nack,
  input logic [7:0] tx_byte,
  input logic       tx_drive
);

  logic       wr_open_q, rx_q;
  logic [7:0] acks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_open_q <= 1'b0;
      rx_q      <= 1'b0;
      acks_q    <= 8'd0;
    end else begin
      rx_q <= ev_rx;
      if (ev_start || ev_stop)  wr_open_q <= 1'b0;
      else if (ev_addr)         wr_open_q <= !addr_rd;
      if (ev_addr)              acks_q <= 8'd0;
      else if (rx_q && ack_o)   acks_q <= acks_q + 8'd1;
    end
  end

  AST_EVENTS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start, ev_stop, ev_addr, ev_rx, ev_tx})); // R12

  AST_UNADDRESSED_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx && !wr_open_q) |=> !ack_o); // R12

  AST_ACK_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    acks_q <= 8'(NREG + 3)); // R6

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr && addr_rd) |=> tx_drive); // R8

  AST_NACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx && tx_nack) |=> !tx_drive); // R8

  AST_FRAME_END_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start || ev_stop) |=> !tx_drive); // R11

  AST_TX_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_drive && !ev_tx && !ev_start && !ev_stop && !ev_addr) |=> $stable(tx_byte)); // R7

endmodule

bind smbus_reg_responder smbr_checker #(.NREG(NREG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev_start (ev_start),
  .ev_stop  (ev_stop),
  .ev_addr  (ev_addr),
  .addr_rd  (addr_rd),
  .ev_rx    (ev_rx),
  .ack_o    (ack_o),
  .ev_tx    (ev_tx),
  .tx_nack  (tx_nack),
  .tx_byte  (tx_byte),
  .tx_drive (tx_drive)
);

// File: tb/test_smbus_reg_responder.sv
`timescale 1ns/1ps
module test_smbus_reg_responder;

  localparam int         NREG = 32;
  localparam logic [6:0] OWN  = 7'h3A;

  logic clk = 1'b0;
  logic rst_n, pec_en, ev_start, ev_stop, ev_addr, addr_rd, ev_rx, ev_tx, tx_nack;
  logic [7:0] rx_byte, tx_byte;
  logic ack_o, tx_drive;

  always #2 clk = ~clk;

  smbus_reg_responder #(.NREG(NREG), .OWN_ADDR(OWN)) i_smbus_reg_responder (
    .clk(clk), .rst_n(rst_n), .pec_en(pec_en), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_addr(ev_addr), .addr_rd(addr_rd), .ev_rx(ev_rx), .rx_byte(rx_byte), .ack_o(ack_o),
    .ev_tx(ev_tx), .tx_nack(tx_nack), .tx_byte(tx_byte), .tx_drive(tx_drive)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] mem_m [NREG];
  logic [7:0] ptr_m;
  int blklen_m;
  logic [7:0] wbuf [48];

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  function automatic int exp_rd(input int i);
    int idx;
    idx = int'(ptr_m[4:0]);
    if (ptr_m[6:5] >= 2) return (i == 0) ? blklen_m : int'(mem_m[(idx + i - 1) % NREG]);
    return int'(mem_m[(idx + i) % NREG]);
  endfunction

  task automatic chk(input string rq, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, expv);
    end
  endtask

  task automatic bus_start();
    @(negedge clk); ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
  endtask
  task automatic bus_stop();
    @(negedge clk); ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
  endtask
  task automatic bus_addr(input logic rd);
    @(negedge clk); ev_addr = 1'b1; addr_rd = rd; @(negedge clk); ev_addr = 1'b0;
  endtask
  task automatic send(input logic [7:0] b, output logic a);
    @(negedge clk); rx_byte = b; ev_rx = 1'b1; @(negedge clk); ev_rx = 1'b0; a = ack_o;
  endtask
  task automatic recv(input logic nack, output logic [7:0] b, output logic d);
    @(negedge clk); b = tx_byte; d = tx_drive; ev_tx = 1'b1; tx_nack = nack;
    @(negedge clk); ev_tx = 1'b0; tx_nack = 1'b0;
  endtask

  // pk: 0 no check byte, 1 correct check byte, 2 corrupted check byte
  task automatic wr_txn(input logic [7:0] cmd, input int n, input int pk, input string rq);
    int mode, idx, expn, nacc;
    bit cseen, over, pseen, pok;
    logic ea, a;
    logic [7:0] b, crc;
    logic [7:0] stg [NREG];
    mode = int'(cmd[6:5]); idx = int'(cmd[4:0]);
    expn = (mode == 0) ? 1 : (mode == 1) ? 2 : 0;
    nacc = 0; cseen = 0; over = 0; pseen = 0; pok = 0;
    crc = crc_step(8'h00, {OWN, 1'b0});
    bus_start(); bus_addr(1'b0);
    send(cmd, a); chk({rq, " command ack (R2)"}, int'(a), 1);
    crc = crc_step(crc, cmd);
    ptr_m = cmd;
    for (int j = 0; j < n + ((pk != 0) ? 1 : 0); j++) begin
      b = (j < n) ? wbuf[j] : ((pk == 1) ? crc : (crc ^ 8'h5A));
      if (mode >= 2 && !cseen) begin
        cseen = 1; over = (b > 8'(NREG)); expn = over ? NREG : int'(b); ea = 1;
      end else if (nacc < expn) begin
        stg[nacc] = b; nacc++; ea = 1;
      end else if (pec_en && !pseen && !over) begin
        pseen = 1; pok = (b == crc); ea = 1;
      end else ea = 0;
      send(b, a);
      chk({rq, " data ack"}, int'(a), int'(ea));
      crc = crc_step(crc, b);
    end
    bus_stop();
    if (nacc > 0 && (!pec_en || (pseen && pok))) begin
      for (int k = 0; k < nacc; k++) mem_m[(idx + k) % NREG] = stg[k];
      if (mode >= 2) blklen_m = nacc;
    end
  endtask

  task automatic rd_txn(input bit with_cmd, input logic [7:0] cmd, input int n, input string rq);
    logic a, d;
    logic [7:0] b;
    if (with_cmd) begin
      bus_start(); bus_addr(1'b0);
      send(cmd, a); chk({rq, " command ack (R2)"}, int'(a), 1);
      ptr_m = cmd;
    end
    bus_start(); bus_addr(1'b1);
    for (int i = 0; i < n; i++) begin
      recv(i == n - 1, b, d);
      chk({rq, " read byte"}, {23'd0, d, b}, 256 + exp_rd(i));
    end
    chk({rq, " release after NACK (R8)"}, {23'd0, tx_drive, tx_byte}, 255);
    bus_stop();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, d;
    logic [7:0] b;
    int op, cnt, n;
    rst_n = 1'b0; pec_en = 1'b0; ev_start = 0; ev_stop = 0; ev_addr = 0; addr_rd = 0;
    ev_rx = 0; ev_tx = 0; tx_nack = 0; rx_byte = 8'h00;
    for (int i = 0; i < NREG; i++) mem_m[i] = 8'h00;
    ptr_m = 8'h00; blklen_m = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ack_o", int'(ack_o), 0);
    chk("R1 tx_drive/tx_byte", {23'd0, tx_drive, tx_byte}, 255);
    rd_txn(0, 8'h00, 1, "R1 register 0 via reset pointer");
    rd_txn(1, 8'h40, 1, "R7 block length after reset");

    // R12 byte outside an addressed write
    send(8'h33, a); chk("R12 unaddressed byte NACK", int'(a), 0);

    // R4 byte access, extra byte NACKed; R3 receive with no command
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
    wr_txn(8'h05, 2, 0, "R4 byte write");
    rd_txn(1, 8'h05, 2, "R4 byte read");
    rd_txn(0, 8'h00, 1, "R3 no-command read");
    rd_txn(0, 8'h00, 1, "R3 no-command read again");

    // R2 bit 7 ignored
    wbuf[0] = 8'h9E;
    wr_txn(8'h89, 1, 0, "R2 bit7 set byte write");
    rd_txn(1, 8'h09, 1, "R2 same register without bit7");

    // R5 word access with wrap at index 31
    wbuf[0] = 8'h12; wbuf[1] = 8'h34;
    wr_txn(8'h3F, 2, 0, "R5 word write wrap");
    rd_txn(1, 8'h3F, 2, "R5 word read wrap");

    // R6/R7 block write and read
    wbuf[0] = 8'd3; wbuf[1] = 8'hC1; wbuf[2] = 8'hC2; wbuf[3] = 8'hC3; wbuf[4] = 8'hEE;
    wr_txn(8'h4A, 5, 0, "R6 block write count 3 plus extra");
    rd_txn(1, 8'h4A, 4, "R7 block read");

    // R6 count above 32: byte 33 NACKed, length clamped
    wbuf[0] = 8'd40;
    for (int k = 1; k <= 33; k++) wbuf[k] = 8'(k * 7);
    wr_txn(8'h40, 34, 0, "R6 oversized block");
    rd_txn(1, 8'h40, 34, "R7 clamped block read");

    // R9 command only
    wr_txn(8'h2A, 0, 0, "R9 command-only write");
    rd_txn(0, 8'h00, 2, "R9 pointer moved, data unchanged");

    // R11 repeated START discards staged data
    wbuf[0] = 8'h77;
    wr_txn(8'h07, 1, 0, "R11 setup");
    bus_start(); bus_addr(1'b0);
    send(8'h07, a); chk("R11 command ack", int'(a), 1);
    send(8'h11, a); chk("R11 staged data ack", int'(a), 1);
    bus_start(); bus_addr(1'b1);
    recv(1'b1, b, d); chk("R11 old data before STOP", int'(b), 8'h77);
    bus_stop();
    rd_txn(0, 8'h00, 1, "R11 data dropped on repeated START");

    // R10 check byte good, bad and missing
    pec_en = 1'b1;
    wbuf[0] = 8'h5D; wbuf[1] = 8'hE3;
    wr_txn(8'h30, 2, 1, "R10 good check word");
    rd_txn(1, 8'h30, 2, "R10 committed");
    wbuf[0] = 8'h01;
    wr_txn(8'h10, 1, 2, "R10 bad check byte");
    rd_txn(1, 8'h10, 1, "R10 discarded");
    wbuf[0] = 8'h02;
    wr_txn(8'h11, 1, 0, "R10 missing check byte");
    rd_txn(1, 8'h11, 1, "R10 discarded when missing");
    wbuf[0] = 8'd2; wbuf[1] = 8'hB0; wbuf[2] = 8'hB1;
    wr_txn(8'h58, 3, 1, "R10 good check block");
    rd_txn(1, 8'h58, 3, "R10 block committed");
    pec_en = 1'b0;

    // random mix
    for (int it = 0; it < 80; it++) begin
      op = int'($urandom % 5);
      pec_en = ($urandom % 3) == 0;
      case (op)
        0: begin
          wbuf[0] = 8'($urandom);
          wr_txn({3'b000, 5'($urandom)}, 1, int'($urandom % 3), "R4 random byte write");
        end
        1: begin
          wbuf[0] = 8'($urandom); wbuf[1] = 8'($urandom);
          wr_txn({3'b001, 5'($urandom)}, 2, int'($urandom % 3), "R5 random word write");
        end
        2: begin
          cnt = int'($urandom % 37);
          wbuf[0] = 8'(cnt);
          n = (cnt > 32) ? 33 : cnt;
          for (int k = 1; k <= n; k++) wbuf[k] = 8'($urandom);
          wr_txn({2'b01, 1'($urandom), 5'($urandom)}, n + 1, int'($urandom % 3), "R6 random block write");
        end
        3: rd_txn(1, {1'b0, 2'($urandom), 5'($urandom)}, 1 + int'($urandom % 6), "R7 random read");
        default: rd_txn(0, 8'h00, 1 + int'($urandom % 3), "R3 random no-command read");
      endcase
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule